// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped First-Level Cache

This block is a small fully-associative store that sits on the refill path of a direct-mapped first-level cache. When the cache misses, it presents the requested line address and, if the slot at that index is occupied, the line that occupies it. The buffer compares the requested address against every stored line in parallel. On a match it returns the stored line one cycle later without contacting lower memory. In the same cycle it takes the cache's displaced line into the entry that was just freed, so the two lines trade places.

On a miss in the buffer, the block issues a single refill request to lower memory and waits. When the response arrives, it forwards the refill data to the cache. At the same moment it keeps the displaced line. That line goes into a free entry if one exists; otherwise it replaces the least recently used entry. The requested line is never put in the buffer. A pair of lines that conflict on one cache index can therefore alternate forever without going to memory after the first two fetches.

Top module: `victim_buf`

## Requirements
- R1: After synchronous active-low reset every entry is invalid, `miss_ready_o` is 1, and `resp_valid_o` and `mem_req_valid_o` are 0, so the first lookup of any address goes to memory.
- R2: A lookup hits only when a valid entry holds exactly the requested line address, all `ADDR_W` bits compared. At most one entry matches at a time.
- R3: A lookup accepted (`miss_valid_i` and `miss_ready_o`) that hits raises `resp_valid_o` with `resp_hit_o`=1 on the next cycle, with the stored line on `resp_data_o`, and no refill request is made.
- R4: On a hit the matched entry is overwritten with the displaced line in the same cycle, so the requested line leaves the buffer and the displaced line can hit afterwards.
- R5: A lookup accepted that misses raises `mem_req_valid_o` for exactly one cycle, on the next cycle, with `mem_req_addr_o` equal to the requested address. `miss_ready_o` stays 0 until the refill returns.
- R6: The cycle after `mem_rsp_valid_i` while waiting, `resp_valid_o`=1, `resp_hit_o`=0, `resp_data_o` equals the refill data, and `miss_ready_o` is 1 again.
- R7: When a refill completes, the displaced line captured with the lookup is written into the buffer, and the requested line is not.
- R8: A refill places the displaced line in the lowest-numbered invalid entry if any exists, otherwise over the least recently used entry. Hits and fills both count as use.
- R9: With `evict_valid_i`=0, nothing is inserted. A hit then leaves its entry invalid, and a later fill uses that entry without pushing any valid line out.
- R10: `mem_rsp_valid_i` while no refill is outstanding produces no response.
- R11: Two addresses that share one cache index, accessed alternately, are each served by the buffer from their third access on.
- R12: `miss_valid_i` while a refill is outstanding is ignored: it produces no request and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid_i | input | 1 | First-level cache missed; lookup requested |
| miss_addr_i | input | ADDR_W | Requested line address |
| evict_valid_i | input | 1 | The cache slot being replaced holds a valid line |
| evict_addr_i | input | ADDR_W | Line address of the displaced line |
| evict_data_i | input | DATA_W | Contents of the displaced line |
| miss_ready_o | output | 1 | Block can accept a lookup this cycle |
| resp_valid_o | output | 1 | Line for the cache is on `resp_data_o` |
| resp_hit_o | output | 1 | 1 when the line came from the buffer, 0 when from memory |
| resp_data_o | output | DATA_W | Line returned to the cache |
| mem_req_valid_o | output | 1 | One-cycle refill request to lower memory |
| mem_req_addr_o | output | ADDR_W | Refill line address |
| mem_rsp_valid_i | input | 1 | Refill data valid |
| mem_rsp_data_i | input | DATA_W | Refill line contents |

## Verification
The hardest state to reach from the ports is a full buffer whose recency order differs from its fill order, followed by a fill that must push out the right line. The stimulus fills all entries through refills with displaced lines, touches an older entry through a swap hit, and then forces one more refill. It next probes both the line that should be gone and the lines that should remain. A hit with no displaced line opens a hole in the middle of a full buffer, and a later fill must use that hole rather than the oldest line. Expected hit or miss results come from an ordered list kept in the bench.

// File: rtl/vb_pkg.sv
// Package: shared types of the victim buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package vb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,   // ready for a lookup
        ST_WAIT = 1'b1    // refill outstanding at lower memory
    } vb_state_e;
endpackage

// File: rtl/vb_match.sv
// Module: vb_match
// Compares the lookup address with every stored line address in parallel
// and encodes the matching entry number.
// Assumes: at most one valid entry holds a given address.
module vb_match #(
    parameter int N  = 4,
    parameter int AW = 12,
    parameter int IW = 2
) (
    input  logic [N-1:0]  valid_i,
    input  logic [AW-1:0] tag_i [N],
    input  logic [AW-1:0] key_i,
    output logic [N-1:0]  hit_vec_o,
    output logic          hit_o,
    output logic [IW-1:0] hit_idx_o
);
    // One full-width comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (tag_i[g] == key_i);
    end

    assign hit_o = |hit_vec_o;

    // Encode the matching entry number.
    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec_o[i]) hit_idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/vb_repl.sv
// Module: vb_repl
// Keeps a recency rank per entry (0 = most recent, N-1 = least recent)
// and names the entry a fill should write: lowest free entry, else oldest.
// Assumes: touch_idx_i is below N whenever touch_i is high.
module vb_repl #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_i,
    input  logic [IW-1:0] touch_idx_i,
    input  logic [N-1:0]  valid_i,
    output logic [IW-1:0] victim_idx_o
);
    logic [IW-1:0] age_q [N];

    // Move the touched entry to rank 0; age every entry that was younger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
        end else if (touch_i) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx_i)            age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Pick the lowest free entry, or the oldest one when all are valid.
    always_comb begin
        logic found;
        found        = 1'b0;
        victim_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && !valid_i[i]) begin
                victim_idx_o = IW'(i);
                found        = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (age_q[i] == IW'(N - 1)) victim_idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vb_entries.sv
// Module: vb_entries
// Storage of N lines: valid bit, line address and line contents, one write
// port. Only valid bits are reset.
// Assumes: wr_idx_i is below N whenever wr_en_i is high.
module vb_entries #(
    parameter int N  = 4,
    parameter int AW = 12,
    parameter int DW = 32,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic          wr_valid_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [N-1:0]  valid_o,
    output logic [AW-1:0] addr_o [N],
    output logic [DW-1:0] data_o [N]
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic          v_q;
        logic [AW-1:0] a_q;
        logic [DW-1:0] d_q;

        // Valid bit: cleared by reset, set or cleared by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      v_q <= 1'b0;
            else if (wr_en_i && (wr_idx_i == IW'(g)))        v_q <= wr_valid_i;
        end

        // Address and contents: plain registers loaded on a write.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == IW'(g))) begin
                a_q <= wr_addr_i;
                d_q <= wr_data_i;
            end
        end

        assign valid_o[g] = v_q;
        assign addr_o[g]  = a_q;
        assign data_o[g]  = d_q;
    end
endmodule

// File: rtl/victim_buf.sv
// Module: victim_buf (top)
// Fully-associative victim buffer on the refill path of a direct-mapped
// cache. Hit: swap with the displaced line, answer next cycle. Miss: one
// refill request, then keep the displaced line when the refill returns.
// Assumes: the cache and the buffer never hold the same line; lower memory
// answers each request once, no earlier than the cycle after it.
module victim_buf #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid_i,
    input  logic [ADDR_W-1:0] miss_addr_i,
    input  logic              evict_valid_i,
    input  logic [ADDR_W-1:0] evict_addr_i,
    input  logic [DATA_W-1:0] evict_data_i,
    output logic              miss_ready_o,
    output logic              resp_valid_o,
    output logic              resp_hit_o,
    output logic [DATA_W-1:0] resp_data_o,
    output logic              mem_req_valid_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i
);
    import vb_pkg::*;

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    vb_state_e         state_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              ev_valid_q;
    logic [ADDR_W-1:0] ev_addr_q;
    logic [DATA_W-1:0] ev_data_q;
    logic              req_pulse_q;
    logic              resp_valid_q;
    logic              resp_hit_q;
    logic [DATA_W-1:0] resp_data_q;

    logic [ENTRIES-1:0] ent_valid;
    logic [ADDR_W-1:0]  ent_addr [ENTRIES];
    logic [DATA_W-1:0]  ent_data [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic [IW-1:0]      hit_idx;
    logic [IW-1:0]      victim_idx;

    logic              accept, take_hit, take_miss, fill;
    logic              wr_en, wr_valid, touch;
    logic [IW-1:0]     wr_idx;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    vb_entries #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W), .IW(IW)) u_ent (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .valid_o(ent_valid), .addr_o(ent_addr), .data_o(ent_data)
    );

    vb_match #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_match (
        .valid_i(ent_valid), .tag_i(ent_addr), .key_i(miss_addr_i),
        .hit_vec_o(hit_vec), .hit_o(hit_any), .hit_idx_o(hit_idx)
    );

    vb_repl #(.N(ENTRIES), .IW(IW)) u_repl (
        .clk(clk), .rst_n(rst_n),
        .touch_i(touch), .touch_idx_i(wr_idx),
        .valid_i(ent_valid), .victim_idx_o(victim_idx)
    );

    // Classify this cycle's event.
    always_comb begin
        accept    = miss_valid_i && (state_q == ST_IDLE);
        take_hit  = accept && hit_any;
        take_miss = accept && !hit_any;
        fill      = (state_q == ST_WAIT) && mem_rsp_valid_i;
    end

    // Select the storage write: swap on a hit, displaced line on a fill.
    always_comb begin
        wr_en    = 1'b0;
        wr_valid = 1'b0;
        wr_idx   = hit_idx;
        wr_addr  = evict_addr_i;
        wr_data  = evict_data_i;
        touch    = 1'b0;
        if (take_hit) begin
            wr_en    = 1'b1;
            wr_valid = evict_valid_i;
            touch    = 1'b1;
        end else if (fill && ev_valid_q) begin
            wr_en    = 1'b1;
            wr_valid = 1'b1;
            wr_idx   = victim_idx;
            wr_addr  = ev_addr_q;
            wr_data  = ev_data_q;
            touch    = 1'b1;
        end
    end

    // Sequencer: idle/waiting state and the captured lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ev_valid_q <= 1'b0;
        end else if (take_miss) begin
            state_q    <= ST_WAIT;
            ev_valid_q <= evict_valid_i;
        end else if (fill) begin
            state_q    <= ST_IDLE;
            ev_valid_q <= 1'b0;
        end
    end

    // Captured address and displaced line, held while waiting.
    always_ff @(posedge clk) begin
        if (take_miss) begin
            req_addr_q <= miss_addr_i;
            ev_addr_q  <= evict_addr_i;
            ev_data_q  <= evict_data_i;
        end
    end

    // Output registers: request pulse and response to the cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_pulse_q  <= 1'b0;
            resp_valid_q <= 1'b0;
            resp_hit_q   <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            req_pulse_q  <= take_miss;
            resp_valid_q <= take_hit || fill;
            if (take_hit) begin
                resp_hit_q  <= 1'b1;
                resp_data_q <= ent_data[hit_idx];
            end else if (fill) begin
                resp_hit_q  <= 1'b0;
                resp_data_q <= mem_rsp_data_i;
            end
        end
    end

    assign miss_ready_o    = (state_q == ST_IDLE);
    assign resp_valid_o    = resp_valid_q;
    assign resp_hit_o      = resp_hit_q;
    assign resp_data_o     = resp_data_q;
    assign mem_req_valid_o = req_pulse_q;
    assign mem_req_addr_o  = req_addr_q;
endmodule

// File: rtl/vb_checker.sv
// Module: vb_checker
// Clocked properties on the victim buffer's ports and match vector,
// attached to every victim_buf instance by the bind below.
// Assumes: the same clock and reset as the checked instance.
module vb_checker #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               miss_valid_i,
    input logic               miss_ready_o,
    input logic               resp_valid_o,
    input logic               resp_hit_o,
    input logic               mem_req_valid_o,
    input logic               mem_rsp_valid_i,
    input logic [ENTRIES-1:0] hit_vec
);
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R2
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid_i && miss_ready_o && (|hit_vec)) |=> (resp_valid_o && resp_hit_o)); // R3
    AST_HIT_NO_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_hit_o) |-> !mem_req_valid_o); // R3
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |=> !mem_req_valid_o); // R5
    AST_REQ_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !miss_ready_o); // R5
    AST_FILL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_ready_o && mem_rsp_valid_i) |=> (resp_valid_o && !resp_hit_o && miss_ready_o)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_ready_o && !miss_valid_i) |=> !resp_valid_o); // R10
    AST_BUSY_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_ready_o && !mem_rsp_valid_i) |=> (!resp_valid_o && !mem_req_valid_o)); // R12
endmodule

bind victim_buf vb_checker #(.ENTRIES(ENTRIES)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .miss_valid_i(miss_valid_i), .miss_ready_o(miss_ready_o),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .hit_vec(hit_vec)
);

// File: tb/victim_buf_tb_top.sv
// Scoreboard bench: the driver pushes expected responses, the monitor pops
// and compares them. A list model (most recent first) predicts hits.
module victim_buf_tb_top;
    localparam int N  = 4;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid_i = 1'b0;
    logic [AW-1:0] miss_addr_i = '0;
    logic          evict_valid_i = 1'b0;
    logic [AW-1:0] evict_addr_i = '0;
    logic [DW-1:0] evict_data_i = '0;
    logic          miss_ready_o, resp_valid_o, resp_hit_o, mem_req_valid_o;
    logic [DW-1:0] resp_data_o;
    logic [AW-1:0] mem_req_addr_o;
    logic          mem_rsp_valid_i = 1'b0;
    logic [DW-1:0] mem_rsp_data_i = '0;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic          hit;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t          sb_q[$];
    logic [AW-1:0] mdl[$];

    always #4 clk = ~clk;   // 125 MHz

    victim_buf #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid_i(miss_valid_i), .miss_addr_i(miss_addr_i),
        .evict_valid_i(evict_valid_i), .evict_addr_i(evict_addr_i),
        .evict_data_i(evict_data_i),
        .miss_ready_o(miss_ready_o), .resp_valid_o(resp_valid_o),
        .resp_hit_o(resp_hit_o), .resp_data_o(resp_data_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i)
    );

    function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
        return {8'hA5, 4'h0, a, ~a[7:0]};
    endfunction
    function automatic logic [DW-1:0] vic_word(logic [AW-1:0] a);
        return {8'h3C, 4'h0, a, a[7:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare every response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && resp_valid_o) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R12 unexpected response", {resp_hit_o, resp_data_o}, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({resp_hit_o, resp_data_o} == {e.hit, e.data}, e.tag,
                    {resp_hit_o, resp_data_o}, {e.hit, e.data});
            end
        end
    end

    // One cache miss. force_hit: -1 model decides, 0/1 forced expectation.
    task automatic do_miss(input logic [AW-1:0] a, input logic ev_v, input logic [AW-1:0] ev_a,
                           input int force_hit, input bit poke, input string tag);
        int  pos = -1;
        bit  eh;
        exp_t e;
        for (int i = 0; i < mdl.size(); i++) if (mdl[i] == a) pos = i;
        eh = (force_hit < 0) ? (pos >= 0) : (force_hit == 1);
        e.hit = eh; e.data = eh ? vic_word(a) : mem_word(a); e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        while (!miss_ready_o) @(negedge clk);
        miss_valid_i = 1'b1; miss_addr_i = a;
        evict_valid_i = ev_v; evict_addr_i = ev_a; evict_data_i = vic_word(ev_a);
        @(negedge clk);
        miss_valid_i = 1'b0; evict_valid_i = 1'b0;
        if (eh) begin
            chk(resp_valid_o && resp_hit_o && !mem_req_valid_o, {tag, " R3 hit timing"},
                {resp_valid_o, resp_hit_o, mem_req_valid_o}, 3'b110);
        end else begin
            chk(mem_req_valid_o && !miss_ready_o && mem_req_addr_o == a, {tag, " R5 refill request"},
                {mem_req_valid_o, miss_ready_o, mem_req_addr_o}, {1'b1, 1'b0, a});
            if (poke) begin
                miss_valid_i = 1'b1; miss_addr_i = a ^ 12'h800;
                @(negedge clk);
                miss_valid_i = 1'b0;
                chk(!mem_req_valid_o && !resp_valid_o, "R12 lookup while busy",
                    {mem_req_valid_o, resp_valid_o}, 2'b00);
                @(negedge clk);
            end else begin
                repeat (2) @(negedge clk);
            end
            mem_rsp_valid_i = 1'b1; mem_rsp_data_i = mem_word(a);
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            chk(resp_valid_o && !resp_hit_o && miss_ready_o, {tag, " R6 refill response"},
                {resp_valid_o, resp_hit_o, miss_ready_o}, 3'b101);
        end
        // Model update: most recent first.
        if (pos >= 0) begin
            mdl.delete(pos);
            if (ev_v) mdl.push_front(ev_a);
        end else if (ev_v) begin
            if (mdl.size() == N) void'(mdl.pop_back());
            mdl.push_front(ev_a);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] l1_tag;
        logic          l1_v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(miss_ready_o == 1'b1, "R1 ready after reset", miss_ready_o, 1);
        chk(resp_valid_o == 1'b0, "R1 no response after reset", resp_valid_o, 0);
        chk(mem_req_valid_o == 1'b0, "R1 no request after reset", mem_req_valid_o, 0);

        do_miss(12'h010, 1'b0, 12'h000, 0, 0, "R1 empty buffer misses");
        do_miss(12'h110, 1'b1, 12'h010, 0, 0, "R7 fill keeps displaced");
        do_miss(12'h010, 1'b1, 12'h110, 1, 0, "R3 swap hit");
        do_miss(12'h110, 1'b1, 12'h010, 1, 0, "R4 displaced line now hits");
        do_miss(12'h110, 1'b0, 12'h000, 0, 0, "R4 hit line left buffer");
        do_miss(12'h910, 1'b0, 12'h000, 0, 0, "R2 top bit differs");
        do_miss(12'h110, 1'b0, 12'h000, 0, 0, "R7 requested line not kept");

        // Fill: buffer holds 010; add 201..203 -> full.
        do_miss(12'h301, 1'b1, 12'h201, -1, 0, "R8 fill free entry");
        do_miss(12'h302, 1'b1, 12'h202, -1, 0, "R8 fill free entry");
        do_miss(12'h303, 1'b1, 12'h203, -1, 0, "R8 fill last free entry");
        // Touch 010 by a swap hit: 010 leaves, 204 enters as most recent.
        do_miss(12'h010, 1'b1, 12'h204, 1, 0, "R8 touch by hit");
        // Full: oldest is 201, it must go.
        do_miss(12'h305, 1'b1, 12'h205, 0, 0, "R8 full fill");
        do_miss(12'h201, 1'b0, 12'h000, 0, 0, "R8 oldest was replaced");
        do_miss(12'h202, 1'b1, 12'h202, 1, 0, "R8 newer line kept");

        // Hit with no displaced line opens a hole; next fill uses it.
        do_miss(12'h203, 1'b0, 12'h000, 1, 0, "R9 hit without displaced line");
        do_miss(12'h203, 1'b0, 12'h000, 0, 0, "R9 entry left invalid");
        do_miss(12'h306, 1'b1, 12'h206, 0, 0, "R9 fill into hole");
        do_miss(12'h204, 1'b1, 12'h204, 1, 0, "R9 no valid line pushed out");
        do_miss(12'h205, 1'b1, 12'h205, 1, 0, "R9 no valid line pushed out");
        do_miss(12'h206, 1'b1, 12'h206, 1, 0, "R9 hole was used");

        // Stray refill response while idle.
        @(negedge clk);
        mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 32'hDEAD_BEEF;
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        chk(!resp_valid_o && miss_ready_o, "R10 stray refill ignored",
            {resp_valid_o, miss_ready_o}, 2'b01);

        // Lookup while a refill is outstanding.
        do_miss(12'h3A0, 1'b0, 12'h000, 0, 1, "R12 busy lookup");

        // Ping-pong on one cache index.
        l1_v = 1'b0; l1_tag = '0;
        for (int i = 0; i < 10; i++) begin
            logic [AW-1:0] a;
            a = (i % 2 == 0) ? 12'h023 : 12'h423;
            do_miss(a, l1_v, l1_tag, (i >= 2) ? 1 : 0, 0, "R11 alternating conflict");
            l1_tag = a; l1_v = 1'b1;
        end

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R3 all expected responses seen", sb_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule